// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This unit observes a CPU's bus and raises a break request for on-chip debug. Two comparators, A and B, form a pair that acts either as two independent address matchers or as a single matcher that needs an address hit on A and a data hit on B. A third comparator, C, matches addresses on its own. C can also look into the paged address space by checking a 6-bit page extension together with the upper address byte. Optionally, C also checks the bus read/write direction.

Each group of comparators runs in one of two ways. A forced group latches a hit and raises the break at the next instruction boundary. A tagged group marks the matching opcode fetch, and that mark travels through a small queue that mirrors the instruction pipeline. The break is raised only when the marked opcode executes. A pipeline flush throws away every mark. A raised request stays high until the CPU acknowledges it, and it carries its type: background-debug entry or software interrupt. The unit also holds the 8-bit control register, the loop-arm clear of the C enable, and a trace-debug enable that cannot be set while the A/B pair is on.

Top module: `bkpt_match_unit`

## Requirements
- R1: The control register resets to 0x00 and loads `ctrl_wdata_i` when `ctrl_we_i` is high. Its bits, from bit 7 down to bit 0, are: A/B enable, full mode, background-debug select, A/B tag, C enable, C tag, C read/write compare enable, and C read/write value. It is visible on `ctrl_o` one cycle after the write.
- R2: A write of 1 to the trace enable is ignored while control bit 7 is 1. A write of 0 always clears the trace enable. A write of 1 sets it when bit 7 is 0.
- R3: With control bit 7 at 0, A/B matches never produce a break request.
- R4: With bit 6 at 0 (dual mode), a valid bus cycle whose address equals `cmp_a_i` or `cmp_b_i` is an A/B hit.
- R5: With bit 6 at 1 (full mode), an A/B hit needs the address to equal `cmp_a_i` and `data_i` to equal `cmp_b_i` in the same cycle. An address equal to `cmp_b_i` alone does not hit.
- R6: A forced hit (tag bit 0) is remembered until the next cycle with `boundary_i` high, including that same cycle. `break_req_o` then rises one cycle later and stays high until a cycle with `ack_i` high.
- R7: A tagged hit on an opcode fetch (`fetch_i`) pushes a mark into a queue that holds up to QDEPTH entries. Each `exec_i` pops the oldest entry and raises the break if that entry is marked. `flush_i` empties the queue, and a tagged hit never breaks on a boundary alone.
- R8: `break_bdm_o` takes the value of control bit 5 when a new request is raised (1 = background debug, 0 = software interrupt), and it holds that value while the request is pending.
- R9: With C enabled (bit 3) and `page_sel_i` at 0, C hits when `addr_i` equals `cmp_c_i` over all 16 bits, and the page extension is ignored.
- R10: With `page_sel_i` at 1, C needs `xaddr_i[7:2]` (extended bits 21:16) to equal `c_ext_i`. It also needs {`xaddr_i[1:0]`, `addr_i[13:8]`} to equal `cmp_c_i[15:8]` and `addr_i[7:0]` to equal `cmp_c_i[7:0]`.
- R11: With bit 1 at 1, a C hit also needs `rw_i` to equal bit 0. With bit 1 at 0, `rw_i` is ignored.
- R12: `arm_loop_i` clears control bit 3 on the next edge, and this takes priority over a write in the same cycle.
- R13: Hits from several comparators in the same cycle raise a single request. After it is acknowledged, no second request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| arm_loop_i | input | 1 | Debug armed in loop-capture mode; clears C enable |
| trace_we_i | input | 1 | Trace enable write strobe |
| trace_wdata_i | input | 1 | Trace enable write value |
| cmp_a_i | input | 16 | Comparator A address |
| cmp_b_i | input | 16 | Comparator B address or data |
| cmp_c_i | input | 16 | Comparator C address |
| c_ext_i | input | 6 | Comparator C page extension |
| page_sel_i | input | 1 | Paged compare select for C |
| bus_valid_i | input | 1 | Bus cycle valid |
| addr_i | input | 16 | Bus address |
| xaddr_i | input | 8 | Extended address bits 21:14 |
| data_i | input | 16 | Data bus |
| rw_i | input | 1 | Bus direction, 1 = read |
| fetch_i | input | 1 | Bus cycle is an opcode fetch |
| exec_i | input | 1 | Oldest fetched opcode executes |
| flush_i | input | 1 | Pipeline flush |
| boundary_i | input | 1 | Instruction boundary |
| ack_i | input | 1 | CPU takes the break |
| ctrl_o | output | 8 | Control register contents |
| trace_en_o | output | 1 | Trace-debug enable |
| break_req_o | output | 1 | Break request |
| break_bdm_o | output | 1 | Break type, 1 = background debug |

## Verification
The hardest case is a tagged mark that sits in the pipeline queue behind unmarked entries, or that is flushed before it reaches execution. From the ports this shows up only as the presence or absence of a request several cycles after the fetch. The stimulus sends fetches with and without matches, then pops them one by one and inserts flushes between fetch and execution. A long random phase draws addresses mostly from the comparator values and drives paged and non-paged cycles. It mixes execute, flush, boundary and acknowledge pulses so that these interleavings recur. A behavioural queue model checks them on every clock.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int ADDR_W = 16;
  localparam int XADR_W = 8;
  localparam int EXT_W  = 6;

  typedef struct packed {
    logic ab_en;
    logic full;
    logic bdm_sel;
    logic ab_tag;
    logic c_en;
    logic c_tag;
    logic c_rw_en;
    logic c_rw_val;
  } bkpt_ctrl_t;
endpackage

// File: rtl/bkpt_ab_cmp.sv
module bkpt_ab_cmp
  import bkpt_pkg::*;
(
  input  logic              en_i,
  input  logic              full_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] data_i,
  input  logic [ADDR_W-1:0] cmp_a_i,
  input  logic [ADDR_W-1:0] cmp_b_i,
  output logic              hit_o
);
  logic a_match;
  logic b_match;

  always_comb begin
    a_match = (addr_i == cmp_a_i);
    b_match = full_i ? (data_i == cmp_b_i) : (addr_i == cmp_b_i);
    hit_o   = en_i & (full_i ? (a_match & b_match) : (a_match | b_match));
  end
endmodule

// File: rtl/bkpt_c_cmp.sv
module bkpt_c_cmp
  import bkpt_pkg::*;
(
  input  logic              en_i,
  input  logic              rw_en_i,
  input  logic              rw_val_i,
  input  logic              page_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [XADR_W-1:0] xaddr_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] cmp_c_i,
  input  logic [EXT_W-1:0]  c_ext_i,
  output logic              hit_o
);
  localparam int HB = ADDR_W / 2;

  logic [HB-1:0] hi_ref;
  logic          ext_ok;
  logic          rw_ok;

  always_comb begin
    hi_ref = page_sel_i ? {xaddr_i[1:0], addr_i[ADDR_W-3:HB]} : addr_i[ADDR_W-1:HB];
    ext_ok = ~page_sel_i | (xaddr_i[XADR_W-1:2] == c_ext_i);
    rw_ok  = ~rw_en_i | (rw_i == rw_val_i);
    hit_o  = en_i & ext_ok & rw_ok
           & (hi_ref == cmp_c_i[ADDR_W-1:HB])
           & (addr_i[HB-1:0] == cmp_c_i[HB-1:0]);
  end
endmodule

// File: rtl/bkpt_tag_queue.sv
module bkpt_tag_queue #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush_i,
  input  logic push_i,
  input  logic push_tag_i,
  input  logic pop_i,
  output logic head_tag_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] tag_q, tag_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [CW-1:0]    cnt_after;
  logic             pop_ok;
  logic             push_ok;

  always_comb begin
    pop_ok    = pop_i & (cnt_q != '0);
    cnt_after = cnt_q - CW'(pop_ok);
    push_ok   = push_i & (cnt_after < CW'(DEPTH));
    tag_d     = pop_ok ? (tag_q >> 1) : tag_q;
    cnt_d     = cnt_after + CW'(push_ok);
    for (int i = 0; i < DEPTH; i++) begin
      if (push_ok && (cnt_after == CW'(i))) tag_d[i] = push_tag_i;
    end
    if (flush_i) begin
      tag_d = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      cnt_q <= '0;
    end else begin
      tag_q <= tag_d;
      cnt_q <= cnt_d;
    end
  end

  assign head_tag_o = tag_q[0] & (cnt_q != '0);

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (cnt_q == '0)); // R7
  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R7
endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
  import bkpt_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  input  logic              arm_loop_i,
  input  logic              trace_we_i,
  input  logic              trace_wdata_i,
  input  logic [ADDR_W-1:0] cmp_a_i,
  input  logic [ADDR_W-1:0] cmp_b_i,
  input  logic [ADDR_W-1:0] cmp_c_i,
  input  logic [EXT_W-1:0]  c_ext_i,
  input  logic              page_sel_i,
  input  logic              bus_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [XADR_W-1:0] xaddr_i,
  input  logic [ADDR_W-1:0] data_i,
  input  logic              rw_i,
  input  logic              fetch_i,
  input  logic              exec_i,
  input  logic              flush_i,
  input  logic              boundary_i,
  input  logic              ack_i,
  output logic [7:0]        ctrl_o,
  output logic              trace_en_o,
  output logic              break_req_o,
  output logic              break_bdm_o
);
  bkpt_ctrl_t ctrl_q, ctrl_d;
  logic       trace_q, trace_d;
  logic       fpend_q, fpend_d;
  logic       req_q, req_d;
  logic       bdm_q, bdm_d;
  logic       ctrl_en, trace_en_w;

  logic hit_ab, hit_c;
  logic force_hit, tag_hit, head_tag;
  logic exec_brk, break_set, hold;

  bkpt_ab_cmp u_ab (
    .en_i    (ctrl_q.ab_en & bus_valid_i),
    .full_i  (ctrl_q.full),
    .addr_i  (addr_i),
    .data_i  (data_i),
    .cmp_a_i (cmp_a_i),
    .cmp_b_i (cmp_b_i),
    .hit_o   (hit_ab)
  );

  bkpt_c_cmp u_c (
    .en_i       (ctrl_q.c_en & bus_valid_i),
    .rw_en_i    (ctrl_q.c_rw_en),
    .rw_val_i   (ctrl_q.c_rw_val),
    .page_sel_i (page_sel_i),
    .addr_i     (addr_i),
    .xaddr_i    (xaddr_i),
    .rw_i       (rw_i),
    .cmp_c_i    (cmp_c_i),
    .c_ext_i    (c_ext_i),
    .hit_o      (hit_c)
  );

  bkpt_tag_queue #(.DEPTH(QDEPTH)) u_tq (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush_i),
    .push_i     (bus_valid_i & fetch_i),
    .push_tag_i (tag_hit),
    .pop_i      (exec_i),
    .head_tag_o (head_tag)
  );

  always_comb begin
    force_hit = (hit_ab & ~ctrl_q.ab_tag) | (hit_c & ~ctrl_q.c_tag);
    tag_hit   = (hit_ab & ctrl_q.ab_tag) | (hit_c & ctrl_q.c_tag);
    exec_brk  = exec_i & ~flush_i & head_tag;
    break_set = (boundary_i & (fpend_q | force_hit)) | exec_brk;
    hold      = req_q & ~ack_i;
    req_d     = break_set | hold;
    bdm_d     = (break_set & ~hold) ? ctrl_q.bdm_sel : bdm_q;
    fpend_d   = boundary_i ? 1'b0 : (fpend_q | force_hit);

    ctrl_en = ctrl_we_i | arm_loop_i;
    ctrl_d  = ctrl_we_i ? bkpt_ctrl_t'(ctrl_wdata_i) : ctrl_q;
    if (arm_loop_i) ctrl_d.c_en = 1'b0;

    trace_en_w = trace_we_i;
    if (!trace_wdata_i)      trace_d = 1'b0;
    else if (!ctrl_q.ab_en)  trace_d = 1'b1;
    else                     trace_d = trace_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      trace_q <= 1'b0;
      fpend_q <= 1'b0;
      req_q   <= 1'b0;
      bdm_q   <= 1'b0;
    end else begin
      if (ctrl_en)    ctrl_q  <= ctrl_d;
      if (trace_en_w) trace_q <= trace_d;
      fpend_q <= fpend_d;
      req_q   <= req_d;
      bdm_q   <= bdm_d;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign trace_en_o  = trace_q;
  assign break_req_o = req_q;
  assign break_bdm_o = bdm_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (break_req_o && !ack_i) |=> break_req_o); // R6
  AST_TYPE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (break_req_o && !ack_i) |=> $stable(break_bdm_o)); // R8
  AST_TRACE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[7] && trace_we_i && trace_wdata_i && !trace_en_o) |=> !trace_en_o); // R2
  AST_LOOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    arm_loop_i |=> !ctrl_o[3]); // R12
  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(break_req_o) |-> $past(boundary_i || exec_i)); // R6
endmodule

// File: tb/bkpt_match_unit_tb.sv
module bkpt_match_unit_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int QD = 4;
  localparam logic [15:0] CA = 16'h1234;
  localparam logic [15:0] CB = 16'h5678;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we, arm_loop, trace_we, trace_wdata;
  logic [7:0] ctrl_wdata;
  logic [15:0] cmp_a, cmp_b, cmp_c, addr, data;
  logic [5:0] c_ext;
  logic [7:0] xaddr;
  logic page_sel, bus_valid, rw, fetch, exec_s, flush, boundary, ack;
  logic [7:0] ctrl_o;
  logic trace_en_o, break_req_o, break_bdm_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  bkpt_match_unit #(.QDEPTH(QD)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .arm_loop_i(arm_loop), .trace_we_i(trace_we), .trace_wdata_i(trace_wdata),
    .cmp_a_i(cmp_a), .cmp_b_i(cmp_b), .cmp_c_i(cmp_c), .c_ext_i(c_ext),
    .page_sel_i(page_sel), .bus_valid_i(bus_valid), .addr_i(addr), .xaddr_i(xaddr),
    .data_i(data), .rw_i(rw), .fetch_i(fetch), .exec_i(exec_s), .flush_i(flush),
    .boundary_i(boundary), .ack_i(ack), .ctrl_o(ctrl_o), .trace_en_o(trace_en_o),
    .break_req_o(break_req_o), .break_bdm_o(break_bdm_o)
  );

  // behavioural reference
  logic [7:0] m_ctrl;
  logic m_trace, m_fpend, m_req, m_bdm;
  bit m_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 8'h00; m_trace = 0; m_fpend = 0; m_req = 0; m_bdm = 0;
      m_q.delete();
    end else begin
      bit hab, hc, fh, th, hi_ok, set, hold, head;
      logic [7:0] hi;
      hab = 0;
      if (bus_valid && m_ctrl[7]) begin
        if (m_ctrl[6]) hab = (addr == cmp_a) && (data == cmp_b);
        else           hab = (addr == cmp_a) || (addr == cmp_b);
      end
      hi = page_sel ? {xaddr[1:0], addr[13:8]} : addr[15:8];
      hi_ok = (hi == cmp_c[15:8]) && (addr[7:0] == cmp_c[7:0]);
      hc = bus_valid && m_ctrl[3] && hi_ok
           && (!page_sel || xaddr[7:2] == c_ext)
           && (!m_ctrl[1] || rw == m_ctrl[0]);
      fh = (hab && !m_ctrl[4]) || (hc && !m_ctrl[2]);
      th = (hab && m_ctrl[4]) || (hc && m_ctrl[2]);
      head = (m_q.size() > 0) ? m_q[0] : 1'b0;
      set = (boundary && (m_fpend || fh)) || (exec_s && !flush && head);
      hold = m_req && !ack;
      if (set && !hold) m_bdm = m_ctrl[5];
      m_req = set || hold;
      m_fpend = boundary ? 1'b0 : (m_fpend || fh);
      if (flush) m_q.delete();
      else begin
        if (exec_s && m_q.size() > 0) void'(m_q.pop_front());
        if (bus_valid && fetch && m_q.size() < QD) m_q.push_back(th);
      end
      if (trace_we) begin
        if (!trace_wdata) m_trace = 0;
        else if (!m_ctrl[7]) m_trace = 1;
      end
      if (ctrl_we) m_ctrl = ctrl_wdata;
      if (arm_loop) m_ctrl[3] = 1'b0;
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R1 model ctrl", 16'(ctrl_o), 16'(m_ctrl));
    chk("R2 model trace", 16'(trace_en_o), 16'(m_trace));
    chk("R6 model req", 16'(break_req_o), 16'(m_req));
    chk("R8 model type", 16'(break_bdm_o), 16'(m_bdm));
  end

  task automatic idle();
    ctrl_we = 0; ctrl_wdata = 0; arm_loop = 0; trace_we = 0; trace_wdata = 0;
    bus_valid = 0; addr = 0; data = 0; rw = 0; fetch = 0; exec_s = 0;
    flush = 0; boundary = 0; ack = 0; xaddr = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_ctrl(logic [7:0] v);
    idle(); ctrl_we = 1; ctrl_wdata = v; step(); idle();
  endtask

  task automatic settle();
    idle(); boundary = 1; flush = 1; step();
    idle(); ack = 1; step(); idle();
  endtask

  task automatic hit_cycle(logic [15:0] a, logic [15:0] d);
    idle(); bus_valid = 1; addr = a; data = d; boundary = 1; step(); idle();
  endtask

  initial begin
    #(10 * 150000);
    n_fail++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle();
    cmp_a = CA; cmp_b = CB; cmp_c = 16'h9ABC; c_ext = 6'h2D; page_sel = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    chk("R1 reset ctrl", 16'(ctrl_o), 16'h0);
    chk("R1 reset req", 16'(break_req_o), 16'h0);
    chk("R2 reset trace", 16'(trace_en_o), 16'h0);
    wr_ctrl(8'hA5);
    chk("R1 write", 16'(ctrl_o), 16'hA5);

    // R2 trace lock
    wr_ctrl(8'h80);
    trace_we = 1; trace_wdata = 1; step(); idle();
    chk("R2 set ignored", 16'(trace_en_o), 16'h0);
    wr_ctrl(8'h00);
    trace_we = 1; trace_wdata = 1; step(); idle();
    chk("R2 set ok", 16'(trace_en_o), 16'h1);
    trace_we = 1; trace_wdata = 0; step(); idle();
    chk("R2 clear", 16'(trace_en_o), 16'h0);

    // R3 pair disabled
    hit_cycle(CA, 0);
    chk("R3 no break", 16'(break_req_o), 16'h0);
    settle();

    // R4 dual mode, R6 forced timing
    wr_ctrl(8'h80);
    bus_valid = 1; addr = CB; step(); idle();
    chk("R6 waits for boundary", 16'(break_req_o), 16'h0);
    boundary = 1; step(); idle();
    chk("R4 B address hit", 16'(break_req_o), 16'h1);
    chk("R8 swi type", 16'(break_bdm_o), 16'h0);
    step();
    chk("R6 held", 16'(break_req_o), 16'h1);
    ack = 1; step(); idle();
    chk("R6 ack clears", 16'(break_req_o), 16'h0);
    settle();

    // R5 full mode
    wr_ctrl(8'hC0);
    hit_cycle(CA, CB ^ 16'h1);
    chk("R5 data mismatch", 16'(break_req_o), 16'h0);
    hit_cycle(CB, 0);
    chk("R5 B address alone", 16'(break_req_o), 16'h0);
    hit_cycle(CA, CB);
    chk("R5 address and data", 16'(break_req_o), 16'h1);
    settle();

    // R8 background debug type
    wr_ctrl(8'hA0);
    hit_cycle(CA, 0);
    chk("R8 req", 16'(break_req_o), 16'h1);
    chk("R8 bdm type", 16'(break_bdm_o), 16'h1);
    settle();

    // R7 tagged
    wr_ctrl(8'h90);
    bus_valid = 1; fetch = 1; addr = CA; step(); idle();
    boundary = 1; step(); idle();
    chk("R7 tag not forced", 16'(break_req_o), 16'h0);
    flush = 1; step(); idle();
    exec_s = 1; step(); idle();
    chk("R7 flushed mark", 16'(break_req_o), 16'h0);
    bus_valid = 1; fetch = 1; addr = 16'h0F0F; step();
    addr = CA; step(); idle();
    exec_s = 1; step(); idle();
    chk("R7 unmarked head", 16'(break_req_o), 16'h0);
    exec_s = 1; step(); idle();
    chk("R7 marked executes", 16'(break_req_o), 16'h1);
    settle();

    // R9 non-paged C
    wr_ctrl(8'h08);
    hit_cycle(16'h9ABC, 0);
    chk("R9 C hit", 16'(break_req_o), 16'h1);
    settle();
    hit_cycle(16'h9BBC, 0);
    chk("R9 C high mismatch", 16'(break_req_o), 16'h0);
    settle();

    // R10 paged C
    cmp_c = 16'hC53A; page_sel = 1;
    idle(); bus_valid = 1; addr = 16'h853A; xaddr = {6'h2D, 2'b11}; boundary = 1; step(); idle();
    chk("R10 paged hit", 16'(break_req_o), 16'h1);
    settle();
    idle(); bus_valid = 1; addr = 16'h853A; xaddr = {6'h2C, 2'b11}; boundary = 1; step(); idle();
    chk("R10 ext mismatch", 16'(break_req_o), 16'h0);
    settle();
    page_sel = 0; cmp_c = 16'h9ABC;

    // R11 read/write compare
    wr_ctrl(8'h0B);
    idle(); bus_valid = 1; addr = 16'h9ABC; rw = 0; boundary = 1; step(); idle();
    chk("R11 rw mismatch", 16'(break_req_o), 16'h0);
    idle(); bus_valid = 1; addr = 16'h9ABC; rw = 1; boundary = 1; step(); idle();
    chk("R11 rw match", 16'(break_req_o), 16'h1);
    settle();

    // R12 loop arm clears C enable
    idle(); ctrl_we = 1; ctrl_wdata = 8'h08; arm_loop = 1; step(); idle();
    chk("R12 clear beats write", 16'(ctrl_o), 16'h00);
    hit_cycle(16'h9ABC, 0);
    chk("R12 C off", 16'(break_req_o), 16'h0);
    settle();

    // R13 merged hits
    cmp_c = CA;
    wr_ctrl(8'h88);
    hit_cycle(CA, 0);
    chk("R13 one req", 16'(break_req_o), 16'h1);
    ack = 1; step(); idle();
    chk("R13 ack", 16'(break_req_o), 16'h0);
    step();
    chk("R13 no second", 16'(break_req_o), 16'h0);
    settle();
    cmp_c = 16'h9ABC;

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int sel;
      idle();
      sel = $urandom_range(0, 4);
      case (sel)
        0: addr = CA;
        1: addr = CB;
        2: addr = cmp_c;
        3: addr = {2'($urandom), cmp_c[13:0]};
        default: addr = 16'($urandom);
      endcase
      data = ($urandom_range(0, 1) == 1) ? CB : 16'($urandom);
      page_sel = 1'($urandom);
      xaddr = ($urandom_range(0, 1) == 1) ? {c_ext, cmp_c[15:14]} : 8'($urandom);
      bus_valid = ($urandom_range(0, 3) != 0);
      fetch = 1'($urandom);
      rw = 1'($urandom);
      exec_s = ($urandom_range(0, 2) == 0);
      flush = ($urandom_range(0, 9) == 0);
      boundary = ($urandom_range(0, 2) == 0);
      ack = ($urandom_range(0, 3) == 0);
      ctrl_we = ($urandom_range(0, 15) == 0);
      ctrl_wdata = 8'($urandom);
      arm_loop = ($urandom_range(0, 63) == 0);
      trace_we = ($urandom_range(0, 7) == 0);
      trace_wdata = 1'($urandom);
      step();
    end
    idle();
    step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule